// File: doc/BRIEF.md
# Level-Rechecking DMA Burst Sequencer

This block turns peripheral DMA request lines into bursts of data beats. A peripheral holds its request line high for as long as its FIFO sits past the watermark. Each DMA channel selects one request line through a per-channel map. When the selected line rises, an enabled channel wakes up and moves one burst of `BURST_LEN` beats, which is the watermark amount.

Once the burst ends, the channel looks at a synchronized mirror of the live request levels. If its line is still high, it queues another burst. It keeps doing so until the line reads low. A FIFO that was serviced late, and therefore never drops below its watermark, still gets drained: without this recheck it would never produce a fresh rising edge and the channel would stall.

All channels share one beat port, a valid/ready stream that carries the channel number and the beat position within the burst. Back-pressure rules:
- While `beat_ready_i` is low, the beat stays presented unchanged.
- Bursts are never interleaved.
- Waiting channels win the port by lowest index.

Each finished burst raises a one-cycle per-channel completion pulse, which serves as the callback or interrupt.

Top module: `dma_req_rechecker`

## Requirements
- R1: After reset, `beat_valid_o`, `burst_done_o` and `ch_busy_o` are all zero.
- R2: A rising edge of the request line selected by `ch_map_i[c*SEL_W +: SEL_W]` starts a burst on channel c, provided c is enabled and idle. Every beat of that burst carries `beat_ch_o == c`.
- R3: A burst is exactly `BURST_LEN` accepted beats, with `beat_idx_o` counting 0 up to `BURST_LEN-1`. Beats of one burst are offered on consecutive cycles.
- R4: After each burst the channel samples its request level through a two-flop synchronizer. If the level is high it runs another burst, and this repeats until the level is low. A line held high through N bursts and dropped during the Nth yields exactly N bursts.
- R5: `burst_done_o[c]` pulses for exactly one cycle after the last beat of each burst of channel c, and at most one bit is set at a time.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, the next cycle keeps `beat_valid_o` high with `beat_ch_o` and `beat_idx_o` unchanged.
- R7: A channel whose `ch_en_i` bit is low ignores rising edges on its request line, so no beats appear.
- R8: Activation is edge-triggered. Enabling a channel while its request line is already high starts nothing.
- R9: One request line may start several channels. They are served one burst at a time, lowest channel index first.
- R10: A rising edge that arrives while the channel is busy is held as pending. After the current burst it causes one further burst even if the line has dropped by then.
- R11: At most one channel is in a burst at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_REQ | Level request lines from peripherals |
| ch_en_i | input | NUM_CH | Per-channel activation enable |
| ch_map_i | input | NUM_CH*SEL_W | Request index selected by each channel |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | Peripheral accepts the beat |
| beat_ch_o | output | CH_W | Channel owning the current beat |
| beat_idx_o | output | CNT_W | Beat position within the burst |
| burst_done_o | output | NUM_CH | One-cycle pulse per completed burst |
| ch_busy_o | output | NUM_CH | Channel is not idle |

## Verification
For every channel, mapped to a line different from its own index, the bench sweeps lines held high for one, two and three bursts. This separates a channel that rechecks the live level (N bursts) from one that stops after the first burst or never stops. Stalling the beat port while the line falls makes each end-of-burst decision land on a known level. Further patterns each isolate one feature:
- a disabled channel, to show gating;
- a channel enabled under a line that is already high, to show edge triggering;
- two channels sharing one line, to show fan-out and service order;
- a line that is re-pulsed mid-burst, to show the pending latch.

// File: rtl/dma_rck_pkg.sv
package dma_rck_pkg;
  typedef enum logic [2:0] {
    CH_IDLE,
    CH_WAIT,
    CH_BURST,
    CH_CHECK,
    CH_DONE
  } chan_st_e;
endpackage

// File: rtl/dma_rck_sync.sv
module dma_rck_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, mirr_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      mirr_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= req_i;
      mirr_q <= meta_q;
      prev_q <= mirr_q;
    end
  end

  assign level_o = mirr_q;
  assign rise_o  = mirr_q & ~prev_q;
endmodule

// File: rtl/dma_rck_arb.sv
module dma_rck_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] want_i,
  input  logic         hold_i,
  output logic [N-1:0] grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    if (!hold_i) begin
      for (int i = 0; i < N; i++) begin
        if (want_i[i] && !found) begin
          grant_o[i] = 1'b1;
          found      = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_rck_chan.sv
module dma_rck_chan
  import dma_rck_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             level_i,
  input  logic             grant_i,
  input  logic             fire_i,
  output logic             burst_o,
  output logic             want_o,
  output logic             done_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  chan_st_e         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             pend_q, pend_n;
  logic             trig;

  assign trig = rise_i & en_i;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    pend_n = pend_q | (trig && (st_q != CH_IDLE));
    case (st_q)
      CH_IDLE:  if (trig) st_n = CH_WAIT;
      CH_WAIT:  if (grant_i) begin
                  st_n  = CH_BURST;
                  cnt_n = '0;
                end
      CH_BURST: if (fire_i) begin
                  if (cnt_q == LAST) st_n = CH_CHECK;
                  else               cnt_n = cnt_q + 1'b1;
                end
      CH_CHECK: if (level_i || pend_q) begin
                  st_n   = CH_WAIT;
                  pend_n = 1'b0;
                end else begin
                  st_n = CH_DONE;
                end
      CH_DONE:  if (pend_q || trig) begin
                  st_n   = CH_WAIT;
                  pend_n = 1'b0;
                end else begin
                  st_n = CH_IDLE;
                end
      default:  st_n = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign burst_o = (st_q == CH_BURST);
  assign want_o  = (st_q == CH_WAIT);
  assign done_o  = (st_q == CH_CHECK);
  assign busy_o  = (st_q != CH_IDLE);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dma_req_rechecker.sv
module dma_req_rechecker #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_CH    = 4,
  parameter int BURST_LEN = 4,
  parameter int SEL_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int CNT_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_REQ-1:0]      req_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic [NUM_CH*SEL_W-1:0] ch_map_i,
  output logic                    beat_valid_o,
  input  logic                    beat_ready_i,
  output logic [CH_W-1:0]         beat_ch_o,
  output logic [CNT_W-1:0]        beat_idx_o,
  output logic [NUM_CH-1:0]       burst_done_o,
  output logic [NUM_CH-1:0]       ch_busy_o
);
  logic [NUM_REQ-1:0] lvl, rise;
  logic [NUM_CH-1:0]  ch_burst, ch_want, ch_grant;
  logic [CNT_W-1:0]   ch_cnt [NUM_CH];
  logic               fire;

  dma_rck_sync #(.W(NUM_REQ)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .level_o (lvl),
    .rise_o  (rise)
  );

  dma_rck_arb #(.N(NUM_CH)) u_arb (
    .want_i  (ch_want),
    .hold_i  (|ch_burst),
    .grant_o (ch_grant)
  );

  assign fire = beat_valid_o & beat_ready_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    assign sel = ch_map_i[c*SEL_W +: SEL_W];

    dma_rck_chan #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (ch_en_i[c]),
      .rise_i  (rise[sel]),
      .level_i (lvl[sel]),
      .grant_i (ch_grant[c]),
      .fire_i  (fire),
      .burst_o (ch_burst[c]),
      .want_o  (ch_want[c]),
      .done_o  (burst_done_o[c]),
      .busy_o  (ch_busy_o[c]),
      .cnt_o   (ch_cnt[c])
    );
  end

  always_comb begin
    beat_ch_o  = '0;
    beat_idx_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_burst[c]) begin
        beat_ch_o  = CH_W'(c);
        beat_idx_o = ch_cnt[c];
      end
    end
  end

  assign beat_valid_o = |ch_burst;
endmodule

// File: rtl/dma_rck_chk.sv
module dma_rck_chk #(
  parameter int NUM_CH    = 4,
  parameter int BURST_LEN = 4,
  parameter int CH_W      = 2,
  parameter int CNT_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [CH_W-1:0]   beat_ch_o,
  input logic [CNT_W-1:0]  beat_idx_o,
  input logic [NUM_CH-1:0] burst_done_o,
  input logic [NUM_CH-1:0] ch_burst
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_LEN - 1);

  a_r11_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_burst));

  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=>
      (beat_valid_o && $stable(beat_ch_o) && $stable(beat_idx_o)));

  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && beat_idx_o != LAST) |=>
      (beat_valid_o && beat_idx_o == $past(beat_idx_o) + 1'b1));

  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (|burst_done_o) |->
      $past(beat_valid_o && beat_ready_i && beat_idx_o == LAST));

  a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(burst_done_o));
endmodule

bind dma_req_rechecker dma_rck_chk #(
  .NUM_CH(NUM_CH), .BURST_LEN(BURST_LEN), .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_ch_o    (beat_ch_o),
  .beat_idx_o   (beat_idx_o),
  .burst_done_o (burst_done_o),
  .ch_burst     (ch_burst)
);

// File: tb/sim_dma_req_rechecker.sv
`timescale 1ns/1ps
module sim_dma_req_rechecker;
  localparam int NR = 4, NC = 4, BL = 4, SW = 2, CW = 2, KW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0]    req = '0;
  logic [NC-1:0]    en = '0;
  logic [NC*SW-1:0] map = '0;
  logic             ready = 1'b0;
  logic             valid;
  logic [CW-1:0]    bch;
  logic [KW-1:0]    bidx;
  logic [NC-1:0]    done, busy;

  int checks = 0, fails = 0, beats = 0, dones = 0;
  logic [CW-1:0] seq [0:63];

  always #10 clk = ~clk;

  dma_req_rechecker #(.NUM_REQ(NR), .NUM_CH(NC), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ch_en_i(en), .ch_map_i(map),
    .beat_valid_o(valid), .beat_ready_i(ready), .beat_ch_o(bch),
    .beat_idx_o(bidx), .burst_done_o(done), .ch_busy_o(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (valid && ready) begin
      chk(int'(bidx) == beats % BL, "R3 beat index", int'(bidx), beats % BL);
      if (beats < 64) seq[beats] = bch;
      beats++;
    end
    dones += $countones(done);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (valid) break;
    end
    step(1);
  endtask

  task automatic wait_beats(input int target);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (beats >= target) break;
    end
    step(1);
  endtask

  task automatic clear();
    beats = 0;
    dones = 0;
  endtask

  // channel ch on line rq, line held through n bursts
  task automatic run_hold(input int ch, input int rq, input int n);
    en = '0;
    en[ch] = 1'b1;
    map[ch*SW +: SW] = SW'(rq);
    clear();
    ready = 1'b0;
    req[rq] = 1'b1;
    for (int b = 1; b <= n; b++) begin
      wait_valid();
      if (b == n) begin
        req[rq] = 1'b0;
        step(5);
      end
      ready = 1'b1;
      wait_beats(b * BL);
      ready = 1'b0;
    end
    ready = 1'b1;
    step(15);
    chk(beats == n * BL, "R4 beats for held line", beats, n * BL);
    chk(dones == n, "R5 completion pulses", dones, n);
    for (int i = 0; i < n * BL && i < 64; i++)
      if (seq[i] != CW'(ch)) chk(0, "R2 beat channel", int'(seq[i]), ch);
    chk(busy == '0, "R4 channel back to idle", int'(busy), 0);
    ready = 1'b0;
  endtask

  initial begin
    step(3);
    chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
    chk(done == '0, "R1 done after reset", int'(done), 0);
    chk(busy == '0, "R1 busy after reset", int'(busy), 0);
    rst_n = 1'b1;
    step(2);

    // R2 R3 R4 R5 sweep
    for (int ch = 0; ch < NC; ch++)
      for (int n = 1; n <= 3; n++)
        run_hold(ch, (ch + 1) % NR, n);

    // R7 disabled channel
    en = '0; map[2*SW +: SW] = 2'd3; clear(); ready = 1'b1;
    req[3] = 1'b1; step(12);
    chk(beats == 0, "R7 disabled channel beats", beats, 0);
    chk(busy == '0, "R7 disabled channel busy", int'(busy), 0);
    req[3] = 1'b0; step(5);

    // R8 enable under an already-high line
    en = '0; map[1*SW +: SW] = 2'd0; clear(); ready = 1'b1;
    req[0] = 1'b1; step(6);
    en[1] = 1'b1; step(12);
    chk(beats == 0, "R8 no start without edge", beats, 0);
    req[0] = 1'b0; step(5); en = '0;

    // R9 one line fans out to channels 0 and 2
    map[0 +: SW] = 2'd1; map[2*SW +: SW] = 2'd1; en = 4'b0101;
    clear(); ready = 1'b0; req[1] = 1'b1;
    wait_valid();
    chk(bch == 2'd0, "R9 lowest channel first", int'(bch), 0);
    req[1] = 1'b0; step(5);
    ready = 1'b1; step(25);
    chk(beats == 2 * BL, "R9 beats for two channels", beats, 2 * BL);
    chk(dones == 2, "R9 completion pulses", dones, 2);
    chk(seq[0] == 2'd0 && seq[BL-1] == 2'd0, "R9 first burst owner", int'(seq[BL-1]), 0);
    chk(seq[BL] == 2'd2 && seq[2*BL-1] == 2'd2, "R11 second burst owner", int'(seq[BL]), 2);
    ready = 1'b0; en = '0;

    // R10 edge while busy becomes pending
    map[3*SW +: SW] = 2'd2; en[3] = 1'b1; clear(); req[2] = 1'b1;
    wait_valid();
    req[2] = 1'b0; step(5);
    req[2] = 1'b1; step(5);
    req[2] = 1'b0; step(5);
    ready = 1'b1; step(25);
    chk(beats == 2 * BL, "R10 pending burst beats", beats, 2 * BL);
    chk(dones == 2, "R10 pending completion pulses", dones, 2);
    chk(busy == '0, "R10 idle afterwards", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule